// File: doc/BRIEF.md
# FIFO Threshold and Control Register Loader

This block holds the programmable settings of a synchronous FIFO: an almost-empty offset, an almost-full offset and a six-bit control word. It drives these straight to the FIFO core, which uses them for its flags and optional features. No reset is needed to change them. Software raises a load strobe and then uses the ordinary write path of the FIFO. Each qualified write clock stores the data bus into one register, and an internal pointer then moves on to the next register.

The same strobe together with the read enable turns the FIFO read path into a readback port. Each qualified read clock places the next register on the read data bus, in the same order used for loading. A mode input is sampled while reset is held. If it is high, the control word comes up all ones and the enhanced feature set is selected. If it is low, the control word comes up all zeros, and the loader neither stores nor shows it, so the sequence covers only the two offsets.

Top module: `fifo_prog_regs`

## Requirements
- R1: While `rst` is high at a write-clock edge, both offsets become 63, the write pointer returns to the almost-empty offset, and the read pointer (on the read clock) returns there too with `rd_data` cleared to 0.
- R2: The value of `mode_in` at a reset edge sets `enh_mode`. When it is 1, `ctrl` resets to 6'b111111. When it is 0, `ctrl` resets to 6'b000000.
- R3: When `load` and `wr_en` are both 1 at a write-clock edge, `wr_data[8:0]` goes into the selected offset and the write pointer advances. The order is almost-empty, then almost-full, then control (enhanced mode only), and then back to almost-empty.
- R4: A qualified write to the control slot stores `wr_data[5:0]` into `ctrl`. Higher data bits are discarded.
- R5: When `enh_mode` is 0, the sequence is almost-empty, then almost-full, then wrap. `ctrl` never changes from its reset value.
- R6: A write clock with only one of `load` and `wr_en` high changes no register and does not move the write pointer.
- R7: When `load` and `rd_en` are both 1 at a read-clock edge, `rd_data` shows the selected register, zero-extended to 18 bits, after that edge. The read pointer then advances in the R3/R5 order.
- R8: A read clock with only one of `load` and `rd_en` high leaves `rd_data` unchanged and does not move the read pointer.
- R9: Outside reset, `mode_in` has no effect on `enh_mode`, `ctrl` or the access order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | FIFO write clock, used for loading and reset |
| rd_clk | input | 1 | FIFO read clock, used for readback |
| rst | input | 1 | Synchronous active-high reset |
| mode_in | input | 1 | Mode select, sampled only during reset |
| load | input | 1 | Turns write/read accesses into register accesses |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| wr_data | input | 18 | Write data bus |
| rd_data | output | 18 | Readback data bus |
| ae_offset | output | 9 | Almost-empty offset to the FIFO core |
| af_offset | output | 9 | Almost-full offset to the FIFO core |
| ctrl | output | 6 | Control word to the FIFO core |
| enh_mode | output | 1 | High when enhanced mode was selected at reset |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- registers and `rd_data` stay unchanged on unqualified edges;
- the pointer moves on every qualified access;
- the control slot is never selected in compatible mode;
- the upper readback bits are always zero;
- the mode flag stays fixed between resets;
- the offsets come up at their defaults after a reset edge.

Only the bench scenarios can show that the pointer visits the registers in the right order and wraps correctly in each mode, that readback returns exactly the values loaded, and that the data bits are trimmed to each register's width. They can also show that `mode_in` toggled outside reset leaves the order alone.

// File: rtl/fifo_prog_regs_pkg.sv
package fifo_prog_regs_pkg;

  // Register slot selected by an access pointer; the encoding is the access order.
  typedef enum logic [1:0] {
    SEL_AE   = 2'd0,
    SEL_AF   = 2'd1,
    SEL_CTRL = 2'd2
  } sel_e;

  // Next slot in the access sequence; the control slot only exists in enhanced mode.
  function automatic sel_e sel_next(input sel_e cur, input logic enh);
    sel_e nxt;
    case (cur)
      SEL_AE:  nxt = SEL_AF;
      SEL_AF:  nxt = enh ? SEL_CTRL : SEL_AE;
      default: nxt = SEL_AE;
    endcase
    return nxt;
  endfunction

  // Reset value of the control word for the sampled mode.
  function automatic logic [5:0] ctrl_default(input logic enh);
    return enh ? 6'b111111 : 6'b000000;
  endfunction

endpackage

// File: rtl/fpr_ptr.sv
module fpr_ptr
  import fifo_prog_regs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic enh,
  output sel_e sel
);

  sel_e sel_q;

  always_ff @(posedge clk) begin
    if (rst)       sel_q <= SEL_AE;
    else if (step) sel_q <= sel_next(sel_q, enh);
  end

  assign sel = sel_q;

endmodule

// File: rtl/fpr_bank.sv
module fpr_bank
  import fifo_prog_regs_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int OFS_W       = 9,
  parameter int CTRL_W      = 6,
  parameter int OFS_DEFAULT = 63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_in,
  input  logic              wr_hit,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OFS_W-1:0]  ae_offset,
  output logic [OFS_W-1:0]  af_offset,
  output logic [CTRL_W-1:0] ctrl,
  output logic              enh_mode
);

  localparam logic [OFS_W-1:0] OFS_RST = OFS_W'(OFS_DEFAULT);

  logic [OFS_W-1:0]  ae_q, af_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              enh_q;

  // Mode flag: captured only while reset is held.
  always_ff @(posedge clk) begin
    if (rst) enh_q <= mode_in;
  end

  // Offset registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      ae_q <= OFS_RST;
      af_q <= OFS_RST;
    end else if (wr_hit) begin
      if (sel == SEL_AE) ae_q <= wr_data[OFS_W-1:0];
      if (sel == SEL_AF) af_q <= wr_data[OFS_W-1:0];
    end
  end

  // Control word: writable only when enhanced mode is active.
  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= CTRL_W'(ctrl_default(mode_in));
    else if (wr_hit && enh_q && sel == SEL_CTRL)
      ctrl_q <= wr_data[CTRL_W-1:0];
  end

  assign ae_offset = ae_q;
  assign af_offset = af_q;
  assign ctrl      = ctrl_q;
  assign enh_mode  = enh_q;

endmodule

// File: rtl/fpr_readout.sv
module fpr_readout
  import fifo_prog_regs_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int OFS_W  = 9,
  parameter int CTRL_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hit,
  input  sel_e              sel,
  input  logic [OFS_W-1:0]  ae_offset,
  input  logic [OFS_W-1:0]  af_offset,
  input  logic [CTRL_W-1:0] ctrl,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mux_val;
  logic [DATA_W-1:0] rd_q;

  // Zero-extended view of the selected slot.
  always_comb begin
    case (sel)
      SEL_AE:   mux_val = DATA_W'(ae_offset);
      SEL_AF:   mux_val = DATA_W'(af_offset);
      SEL_CTRL: mux_val = DATA_W'(ctrl);
      default:  mux_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_q <= '0;
    else if (rd_hit) rd_q <= mux_val;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/fifo_prog_regs.sv
module fifo_prog_regs
  import fifo_prog_regs_pkg::*;
#(
  parameter int DATA_W      = 18,
  parameter int OFS_W       = 9,
  parameter int CTRL_W      = 6,
  parameter int OFS_DEFAULT = 63
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              mode_in,
  input  logic              load,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [OFS_W-1:0]  ae_offset,
  output logic [OFS_W-1:0]  af_offset,
  output logic [CTRL_W-1:0] ctrl,
  output logic              enh_mode
);

  // Named access events, also observed by the checker.
  logic wr_hit, rd_hit;
  sel_e wr_sel, rd_sel;

  assign wr_hit = load & wr_en;
  assign rd_hit = load & rd_en;

  fpr_ptr u_wr_ptr (
    .clk  (wr_clk),
    .rst  (rst),
    .step (wr_hit),
    .enh  (enh_mode),
    .sel  (wr_sel)
  );

  fpr_ptr u_rd_ptr (
    .clk  (rd_clk),
    .rst  (rst),
    .step (rd_hit),
    .enh  (enh_mode),
    .sel  (rd_sel)
  );

  fpr_bank #(
    .DATA_W      (DATA_W),
    .OFS_W       (OFS_W),
    .CTRL_W      (CTRL_W),
    .OFS_DEFAULT (OFS_DEFAULT)
  ) u_bank (
    .clk       (wr_clk),
    .rst       (rst),
    .mode_in   (mode_in),
    .wr_hit    (wr_hit),
    .sel       (wr_sel),
    .wr_data   (wr_data),
    .ae_offset (ae_offset),
    .af_offset (af_offset),
    .ctrl      (ctrl),
    .enh_mode  (enh_mode)
  );

  fpr_readout #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W),
    .CTRL_W (CTRL_W)
  ) u_readout (
    .clk       (rd_clk),
    .rst       (rst),
    .rd_hit    (rd_hit),
    .sel       (rd_sel),
    .ae_offset (ae_offset),
    .af_offset (af_offset),
    .ctrl      (ctrl),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/fifo_prog_regs_chk.sv
module fifo_prog_regs_chk #(
  parameter int DATA_W      = 18,
  parameter int OFS_W       = 9,
  parameter int CTRL_W      = 6,
  parameter int OFS_DEFAULT = 63
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst,
  input logic              wr_hit,
  input logic              rd_hit,
  input logic [1:0]        wr_sel,
  input logic [1:0]        rd_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic [OFS_W-1:0]  ae_offset,
  input logic [OFS_W-1:0]  af_offset,
  input logic [CTRL_W-1:0] ctrl,
  input logic              enh_mode
);

  assert_reset_defaults_R1: assert property (@(posedge wr_clk)
    rst |=> (ae_offset == OFS_W'(OFS_DEFAULT) && af_offset == OFS_W'(OFS_DEFAULT)));

  assert_wr_advance_R3: assert property (@(posedge wr_clk) disable iff (rst)
    wr_hit |=> wr_sel != $past(wr_sel));

  assert_ctrl_locked_R5: assert property (@(posedge wr_clk) disable iff (rst)
    !enh_mode |-> (ctrl == '0 && wr_sel != 2'd2));

  assert_regs_hold_R6: assert property (@(posedge wr_clk) disable iff (rst)
    !wr_hit |=> ($stable(ae_offset) && $stable(af_offset) && $stable(ctrl) && $stable(wr_sel)));

  assert_rd_advance_R7: assert property (@(posedge rd_clk) disable iff (rst)
    rd_hit |=> rd_sel != $past(rd_sel));

  assert_rd_upper_zero_R7: assert property (@(posedge rd_clk) disable iff (rst)
    rd_data[DATA_W-1:OFS_W] == '0);

  assert_rd_hold_R8: assert property (@(posedge rd_clk) disable iff (rst)
    !rd_hit |=> ($stable(rd_data) && $stable(rd_sel)));

  assert_mode_fixed_R9: assert property (@(posedge wr_clk) disable iff (rst)
    1'b1 |=> $stable(enh_mode));

endmodule

bind fifo_prog_regs fifo_prog_regs_chk #(
  .DATA_W      (DATA_W),
  .OFS_W       (OFS_W),
  .CTRL_W      (CTRL_W),
  .OFS_DEFAULT (OFS_DEFAULT)
) u_chk (
  .wr_clk    (wr_clk),
  .rd_clk    (rd_clk),
  .rst       (rst),
  .wr_hit    (wr_hit),
  .rd_hit    (rd_hit),
  .wr_sel    (wr_sel),
  .rd_sel    (rd_sel),
  .rd_data   (rd_data),
  .ae_offset (ae_offset),
  .af_offset (af_offset),
  .ctrl      (ctrl),
  .enh_mode  (enh_mode)
);

// File: tb/fifo_prog_regs_bench.sv
`timescale 1ns/1ps
module fifo_prog_regs_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_in = 1'b0;
  logic        load = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [17:0] wr_data = '0;
  logic [17:0] rd_data;
  logic [8:0]  ae_offset, af_offset;
  logic [5:0]  ctrl;
  logic        enh_mode;

  int checks = 0;
  int errors = 0;

  // Reference state.
  logic [8:0] m_ae, m_af;
  logic [5:0] m_ctrl;
  logic       m_enh;
  int         m_wsel, m_rsel;
  logic [17:0] m_rd;

  always #10 clk = ~clk;

  fifo_prog_regs u_fifo_prog_regs (
    .wr_clk(clk), .rd_clk(clk), .rst(rst), .mode_in(mode_in),
    .load(load), .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data),
    .rd_data(rd_data), .ae_offset(ae_offset), .af_offset(af_offset),
    .ctrl(ctrl), .enh_mode(enh_mode)
  );

  function automatic int step_of(input int s, input logic enh);
    if (s == 0) return 1;
    if (s == 1) return enh ? 2 : 0;
    return 0;
  endfunction

  function automatic logic [17:0] view_of(input int s);
    if (s == 0) return {9'b0, m_ae};
    if (s == 1) return {9'b0, m_af};
    return {12'b0, m_ctrl};
  endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " ae_offset"}, {9'b0, ae_offset}, {9'b0, m_ae});
    check({tag, " af_offset"}, {9'b0, af_offset}, {9'b0, m_af});
    check({tag, " ctrl"}, {12'b0, ctrl}, {12'b0, m_ctrl});
    check({tag, " enh_mode"}, {17'b0, enh_mode}, {17'b0, m_enh});
    check({tag, " rd_data"}, rd_data, m_rd);
  endtask

  // Drive at the falling edge, update the model at the rising edge, compare 5 ns later.
  task automatic cyc(input logic r, input logic m, input logic ld, input logic we,
                     input logic re, input logic [17:0] d);
    @(negedge clk);
    rst = r; mode_in = m; load = ld; wr_en = we; rd_en = re; wr_data = d;
    @(posedge clk);
    if (r) begin
      m_enh = m; m_ctrl = m ? 6'h3F : 6'h00;
      m_ae = 9'd63; m_af = 9'd63; m_wsel = 0; m_rsel = 0; m_rd = '0;
    end else begin
      if (ld && we) begin
        if (m_wsel == 0) m_ae = d[8:0];
        else if (m_wsel == 1) m_af = d[8:0];
        else m_ctrl = d[5:0];
        m_wsel = step_of(m_wsel, m_enh);
      end
      if (ld && re) begin
        m_rd = view_of(m_rsel);
        m_rsel = step_of(m_rsel, m_enh);
      end
    end
    #5;
  endtask

  task automatic do_reset(input logic m);
    cyc(1'b1, m, 1'b0, 1'b0, 1'b0, '0);
    cyc(1'b1, m, 1'b0, 1'b0, 1'b0, '0);
    cyc(1'b0, m, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));

    // Enhanced-mode reset defaults.
    do_reset(1'b1);
    check("R1 ae default", {9'b0, ae_offset}, 18'd63);
    check("R1 af default", {9'b0, af_offset}, 18'd63);
    check("R1 rd_data cleared", rd_data, 18'd0);
    check("R2 enh ctrl default", {12'b0, ctrl}, 18'h3F);
    check("R2 enh flag", {17'b0, enh_mode}, 18'd1);

    // Enhanced write order with wrap; upper data bits must be dropped.
    cyc(0, 0, 1, 1, 0, 18'h3FE05);
    check("R3 first write to ae", {9'b0, ae_offset}, 18'h005);
    cyc(0, 0, 1, 1, 0, 18'h2A1C8);
    check("R3 second write to af", {9'b0, af_offset}, 18'h1C8);
    cyc(0, 0, 1, 1, 0, 18'h3FFE5);
    check("R4 ctrl takes low 6 bits", {12'b0, ctrl}, 18'h25);
    cyc(0, 0, 1, 1, 0, 18'h00011);
    check("R3 wrap back to ae", {9'b0, ae_offset}, 18'h011);
    check("R3 af untouched by wrap", {9'b0, af_offset}, 18'h1C8);

    // Readback order with zero extension; the write pointer now sits at af.
    cyc(0, 0, 1, 0, 1, '0);
    check("R7 read ae", rd_data, 18'h011);
    cyc(0, 0, 1, 0, 1, '0);
    check("R7 read af", rd_data, 18'h1C8);
    cyc(0, 0, 1, 0, 1, '0);
    check("R7 read ctrl", rd_data, 18'h25);
    cyc(0, 0, 1, 0, 1, '0);
    check("R7 read wraps to ae", rd_data, 18'h011);

    // Half strobes are ignored.
    cyc(0, 0, 0, 1, 0, 18'h155);
    cyc(0, 0, 1, 0, 0, 18'h0AA);
    check_all("R6 half write strobe");
    cyc(0, 0, 0, 0, 1, '0);
    check("R8 rd_en alone holds", rd_data, 18'h011);
    cyc(0, 0, 1, 1, 0, 18'h0F0);
    check("R6 pointer stayed at af", {9'b0, af_offset}, 18'h0F0);
    cyc(0, 0, 1, 0, 1, '0);
    check("R8 read pointer stayed at af", rd_data, 18'h0F0);

    // A mode toggle outside reset has no effect.
    cyc(0, 0, 0, 0, 0, '0);
    cyc(0, 1, 0, 0, 0, '0);
    check_all("R9 mode toggle");

    // Compatible mode: two-slot ring, ctrl frozen.
    do_reset(1'b0);
    check("R2 compat ctrl default", {12'b0, ctrl}, 18'h00);
    check("R2 compat flag", {17'b0, enh_mode}, 18'd0);
    cyc(0, 0, 1, 1, 0, 18'h0101);
    cyc(0, 0, 1, 1, 0, 18'h0102);
    cyc(0, 0, 1, 1, 0, 18'h0003);
    check("R5 third write wraps to ae", {9'b0, ae_offset}, 18'h003);
    check("R5 ctrl unchanged", {12'b0, ctrl}, 18'h00);
    cyc(0, 1, 1, 0, 1, '0);
    cyc(0, 1, 1, 0, 1, '0);
    cyc(0, 1, 1, 0, 1, '0);
    check("R5 readback skips ctrl", rd_data, 18'h003);
    check_all("R9 compat after mode toggle");

    // Random traffic in both modes; writes and reads never overlap.
    for (int pass = 0; pass < 2; pass++) begin
      do_reset(pass == 0);
      for (int i = 0; i < 300; i++) begin
        int op;
        op = $urandom % 6;
        cyc(0, $urandom % 2, op < 4, op == 0 || op == 1 || op == 4,
            op == 2 || op == 3 || op == 5, 18'($urandom));
        check_all("R3 R7 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule